// File: doc/BRIEF.md
# Debug Signal Output Multiplexer

This block drives a small set of debug output pins from a wide field of internal observation signals. Each pin has its own bus of sixteen candidate signals and a 4-bit selector that picks one of them. Selector codes 0 to 14 pass a bit of that pin's bus through. The top code, 15, puts a software-owned general-purpose output (GPO) bit on the pin instead. Software sets GPO bits through one write-one-to-set register and clears them through another write-one-to-clear register, so no read-modify-write is needed.

A single enable bit gates the whole output stage. While it is off, every pin is held low, and the selector and GPO contents are kept. Reads also return the live pin levels, a version byte and two fixed identification words. The register port takes single-cycle write strobes and single-cycle read strobes. Read data is registered.

Top module: `dbg_obs_mux`

## Requirements
- R1: After reset the enable bit, all selector fields and all GPO bits are 0, every pin output is low, and reads of offsets 0x000, 0x004 and 0x01C return 0.
- R2: Offset 0x000 holds the enable in bit 0. Writing a word stores only bit 0, and a read returns that bit with all other bits 0.
- R3: Offset 0x004 is read/write. Pin n's selector is the field at bits [4n+3:4n], and a read returns the last written word.
- R4: With the enable set and pin n's selector s in 0..14, pin n shows bit s of its observation bus, which is input bits [16n+15:16n]. Pins are registered: a change of an input or a register shows on the pins one clock later.
- R5: With the enable set and pin n's selector equal to 15, pin n shows GPO bit n.
- R6: While the enable is 0, all pins are low from the next clock on. Selector and GPO contents are kept, and the previous routing returns once the enable is set again.
- R7: Writing offset 0x014 sets each GPO bit whose data bit is 1 and leaves the others unchanged. A read of 0x014 returns the GPO bits.
- R8: Writing offset 0x018 clears each GPO bit whose data bit is 1 and leaves the others unchanged. A read of 0x018 returns 0. A write that asks to both set and clear a bit leaves it set.
- R9: Offset 0x01C reads the GPO bits and offset 0x010 reads the current pin levels. Writes to 0x010, 0x01C, 0x3F4, 0x3F8 and 0x3FC change no state.
- R10: Offset 0x3F4 reads the major revision in bits [7:4] and the minor revision in bits [3:0] (defaults 2 and 1, so 0x21). Offsets 0x3F8 and 0x3FC read the identification words (defaults 0x4442_4730 and 0x0000_0008). Unmapped offsets read 0.
- R11: The read data output is loaded on the clock edge where the read strobe is high. It keeps that value until the next read, whatever writes happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_rd_en | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | 10 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| obs_in | input | 128 | Observation buses, pin n at bits [16n+15:16n] |
| dbg_pin | output | 8 | Debug pin levels |

## Verification
A write takes effect on the edge that samples it. The pins follow one edge later, so a result caused by a register write is due two edges after the write is presented. A change of the observation inputs is due one edge after it is presented.

The bench drives on falling edges and samples on falling edges. It checks pins right after a write returns, which confirms the old value is still present, and again one falling edge later, where the new value is due. Read data is taken on the falling edge after the read strobe's rising edge. A later check confirms that this value holds across writes.

// File: rtl/dbg_obs_pkg.sv
package dbg_obs_pkg;

    typedef enum logic [3:0] {
        RS_CTRL,
        RS_MUX,
        RS_PINS,
        RS_GSET,
        RS_GCLR,
        RS_GVAL,
        RS_VER,
        RS_IDENT,
        RS_SIZE,
        RS_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [31:0] byte_addr);
        reg_sel_e r;
        case (byte_addr)
            32'h000: r = RS_CTRL;
            32'h004: r = RS_MUX;
            32'h010: r = RS_PINS;
            32'h014: r = RS_GSET;
            32'h018: r = RS_GCLR;
            32'h01C: r = RS_GVAL;
            32'h3F4: r = RS_VER;
            32'h3F8: r = RS_IDENT;
            32'h3FC: r = RS_SIZE;
            default: r = RS_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_obs_regs.sv
module dbg_obs_regs
    import dbg_obs_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic                      ctrl_en,
    output logic [NUM_PINS*SEL_W-1:0] mux_sel,
    output logic [NUM_PINS-1:0]       gpo
);

    localparam int MUX_W = NUM_PINS * SEL_W;

    typedef struct packed {
        logic                en;
        logic [MUX_W-1:0]    mux;
        logic [NUM_PINS-1:0] gpo;
    } regs_t;

    regs_t               regs_d, regs_q;
    logic [NUM_PINS-1:0] set_mask;
    logic [NUM_PINS-1:0] clr_mask;
    reg_sel_e            wsel;

    always_comb begin
        regs_d   = regs_q;
        set_mask = '0;
        clr_mask = '0;
        wsel     = decode_addr(32'(addr));
        if (wr_en) begin
            case (wsel)
                RS_CTRL: regs_d.en  = wdata[0];
                RS_MUX:  regs_d.mux = wdata[MUX_W-1:0];
                RS_GSET: set_mask   = wdata[NUM_PINS-1:0];
                RS_GCLR: clr_mask   = wdata[NUM_PINS-1:0];
                default: ;
            endcase
        end
        // set has priority over clear on the same bit
        regs_d.gpo = (regs_q.gpo & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl_en = regs_q.en;
    assign mux_sel = regs_q.mux;
    assign gpo     = regs_q.gpo;

endmodule

// File: rtl/dbg_obs_pin_sel.sv
module dbg_obs_pin_sel #(
    parameter int SEL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SEL_W-1:0]    sel,
    input  logic [2**SEL_W-1:0] obs,
    input  logic                gpo_bit,
    output logic                pin
);

    localparam logic [SEL_W-1:0] GPO_CODE = {SEL_W{1'b1}};

    logic pin_d, pin_q;

    always_comb begin
        if (!en) begin
            pin_d = 1'b0;
        end else if (sel == GPO_CODE) begin
            pin_d = gpo_bit;
        end else begin
            pin_d = obs[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin = pin_q;

endmodule

// File: rtl/dbg_obs_rdata.sv
module dbg_obs_rdata
    import dbg_obs_pkg::*;
#(
    parameter int          NUM_PINS    = 8,
    parameter int          SEL_W       = 4,
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 10,
    parameter logic [3:0]  VER_MAJOR   = 4'h2,
    parameter logic [3:0]  VER_MINOR   = 4'h1,
    parameter logic [31:0] IDENT_WORD  = 32'h4442_4730,
    parameter logic [31:0] SIZE_WORD   = 32'h0000_0008
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ctrl_en,
    input  logic [NUM_PINS*SEL_W-1:0] mux_sel,
    input  logic [NUM_PINS-1:0]       gpo,
    input  logic [NUM_PINS-1:0]       pins,
    output logic [DATA_W-1:0]         rdata
);

    localparam int MUX_W = NUM_PINS * SEL_W;

    logic [DATA_W-1:0] rdata_d, rdata_q;
    reg_sel_e          rsel;

    always_comb begin
        rdata_d = rdata_q;
        rsel    = decode_addr(32'(addr));
        if (rd_en) begin
            rdata_d = '0;
            case (rsel)
                RS_CTRL:  rdata_d[0]            = ctrl_en;
                RS_MUX:   rdata_d[MUX_W-1:0]    = mux_sel;
                RS_PINS:  rdata_d[NUM_PINS-1:0] = pins;
                RS_GSET:  rdata_d[NUM_PINS-1:0] = gpo;
                RS_GVAL:  rdata_d[NUM_PINS-1:0] = gpo;
                RS_VER:   rdata_d[7:0]          = {VER_MAJOR, VER_MINOR};
                RS_IDENT: rdata_d               = DATA_W'(IDENT_WORD);
                RS_SIZE:  rdata_d               = DATA_W'(SIZE_WORD);
                default:  rdata_d               = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dbg_obs_mux.sv
module dbg_obs_mux #(
    parameter int          NUM_PINS   = 8,
    parameter int          SEL_W      = 4,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 10,
    parameter logic [3:0]  VER_MAJOR  = 4'h2,
    parameter logic [3:0]  VER_MINOR  = 4'h1,
    parameter logic [31:0] IDENT_WORD = 32'h4442_4730,
    parameter logic [31:0] SIZE_WORD  = 32'h0000_0008
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr_en,
    input  logic                              reg_rd_en,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output logic [DATA_W-1:0]                 reg_rdata,
    input  logic [NUM_PINS*(2**SEL_W)-1:0]    obs_in,
    output logic [NUM_PINS-1:0]               dbg_pin
);

    localparam int SRC_N = 2 ** SEL_W;
    localparam int MUX_W = NUM_PINS * SEL_W;

    logic                ctrl_en;
    logic [MUX_W-1:0]    mux_sel;
    logic [NUM_PINS-1:0] gpo;

    dbg_obs_regs #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ctrl_en  (ctrl_en),
        .mux_sel  (mux_sel),
        .gpo      (gpo)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        dbg_obs_pin_sel #(
            .SEL_W   (SEL_W)
        ) sel_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctrl_en),
            .sel     (mux_sel[n*SEL_W +: SEL_W]),
            .obs     (obs_in[n*SRC_N +: SRC_N]),
            .gpo_bit (gpo[n]),
            .pin     (dbg_pin[n])
        );
    end

    dbg_obs_rdata #(
        .NUM_PINS   (NUM_PINS),
        .SEL_W      (SEL_W),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .VER_MAJOR  (VER_MAJOR),
        .VER_MINOR  (VER_MINOR),
        .IDENT_WORD (IDENT_WORD),
        .SIZE_WORD  (SIZE_WORD)
    ) rdata_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (reg_rd_en),
        .addr       (reg_addr),
        .ctrl_en    (ctrl_en),
        .mux_sel    (mux_sel),
        .gpo        (gpo),
        .pins       (dbg_pin),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/dbg_obs_mux_chk.sv
module dbg_obs_mux_chk #(
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_wr_en,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [DATA_W-1:0]         reg_wdata,
    input logic                      ctrl_en,
    input logic [NUM_PINS*SEL_W-1:0] mux_sel,
    input logic [NUM_PINS-1:0]       gpo,
    input logic [NUM_PINS-1:0]       dbg_pin
);

    localparam int               MUX_W    = NUM_PINS * SEL_W;
    localparam logic [ADDR_W-1:0] A_MUX   = ADDR_W'(32'h004);
    localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(32'h014);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(32'h018);
    localparam logic [SEL_W-1:0]  GPO_CODE = {SEL_W{1'b1}};

    // R6: disabled output stage drives every pin low on the next edge
    p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (dbg_pin == '0));

    // R3: selector word is stored as written
    p_mux_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_MUX) |=> (mux_sel == $past(reg_wdata[MUX_W-1:0])));

    // R7: requested bits are set after a set write
    p_gpo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_SET) |=>
        ((gpo & $past(reg_wdata[NUM_PINS-1:0])) == $past(reg_wdata[NUM_PINS-1:0])));

    // R8: requested bits are cleared after a clear write
    p_gpo_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_CLR) |=> ((gpo & $past(reg_wdata[NUM_PINS-1:0])) == '0));

    // R9: GPO only moves through the set and clear offsets
    p_gpo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && (reg_addr == A_SET || reg_addr == A_CLR)) |=> $stable(gpo));

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_chk
        // R5: top selector code routes the GPO bit one edge later
        p_gpo_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_en && mux_sel[n*SEL_W +: SEL_W] == GPO_CODE) |=> (dbg_pin[n] == $past(gpo[n])));
    end

endmodule

bind dbg_obs_mux dbg_obs_mux_chk #(
    .NUM_PINS (NUM_PINS),
    .SEL_W    (SEL_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctrl_en   (ctrl_en),
    .mux_sel   (mux_sel),
    .gpo       (gpo),
    .dbg_pin   (dbg_pin)
);

// File: tb/dbg_obs_mux_tb_top.sv
`timescale 1ns/1ps
module dbg_obs_mux_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] obs = '0;
    logic [7:0]   pins;

    int errors = 0;
    int checks = 0;
    logic [31:0] lfsr = 32'h1357_9BDF;
    logic [31:0] rv;
    logic [31:0] mux_m;
    logic [7:0]  gpo_m;

    always #2.5 clk = ~clk;

    dbg_obs_mux dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (wr_en),
        .reg_rd_en (rd_en),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .obs_in    (obs),
        .dbg_pin   (pins)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    function automatic logic [7:0] exp_pins(input logic en, input logic [31:0] m,
                                            input logic [7:0] g, input logic [127:0] o);
        logic [7:0] r;
        r = '0;
        for (int n = 0; n < 8; n++) begin
            logic [3:0] s;
            s = m[4*n +: 4];
            if (s == 4'hF) r[n] = g[n];
            else           r[n] = o[16*n + int'(s)];
        end
        return en ? r : 8'h00;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic new_obs();
        for (int w = 0; w < 4; w++) begin
            lfsr = step(lfsr);
            obs[32*w +: 32] = lfsr;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pins", 32'(pins), 32'h0);
        rd(10'h000, rv); check("R1 ctrl", rv, 32'h0);
        rd(10'h004, rv); check("R1 mux", rv, 32'h0);
        rd(10'h01C, rv); check("R1 gpo", rv, 32'h0);

        // R2 enable bit only
        wr(10'h000, 32'hFFFF_FFFF);
        rd(10'h000, rv); check("R2 ctrl one", rv, 32'h1);
        wr(10'h000, 32'hFFFF_FFFE);
        rd(10'h000, rv); check("R2 ctrl zero", rv, 32'h0);
        wr(10'h000, 32'h1);

        // R3 mux readback
        wr(10'h004, 32'h7654_3210);
        rd(10'h004, rv); check("R3 mux readback", rv, 32'h7654_3210);

        // R4 uniform selector sweep
        gpo_m = 8'h00;
        for (int s = 0; s < 15; s++) begin
            mux_m = {8{4'(s)}};
            wr(10'h004, mux_m);
            for (int p = 0; p < 3; p++) begin
                new_obs();
                @(negedge clk);
                check($sformatf("R4 sel=%0d", s), 32'(pins), 32'(exp_pins(1'b1, mux_m, gpo_m, obs)));
            end
        end
        // R3/R4 distinct selector per pin
        for (int k = 0; k < 15; k++) begin
            mux_m = '0;
            for (int n = 0; n < 8; n++) mux_m[4*n +: 4] = 4'((n * 3 + k) % 15);
            wr(10'h004, mux_m);
            for (int p = 0; p < 2; p++) begin
                new_obs();
                @(negedge clk);
                check($sformatf("R3 field k=%0d", k), 32'(pins), 32'(exp_pins(1'b1, mux_m, gpo_m, obs)));
            end
        end

        // R5 GPO routing and R4 latency
        mux_m = 32'hFFFF_FFFF;
        wr(10'h004, mux_m);
        wr(10'h014, 32'hA5);
        check("R4 latency old value", 32'(pins), 32'h00);
        @(negedge clk);
        check("R5 gpo on pins", 32'(pins), 32'hA5);
        rd(10'h01C, rv); check("R7 gpo value", rv, 32'hA5);
        rd(10'h014, rv); check("R7 set reads gpo", rv, 32'hA5);
        wr(10'h014, 32'h0A);
        rd(10'h01C, rv); check("R7 set keeps others", rv, 32'hAF);
        wr(10'h018, 32'h81);
        rd(10'h01C, rv); check("R8 clear", rv, 32'h2E);
        rd(10'h018, rv); check("R8 clear reads zero", rv, 32'h0);
        gpo_m = 8'h2E;
        check("R5 pins after clear", 32'(pins), 32'h2E);

        // mixed GPO and observation routing
        mux_m = 32'h3F3F_3F3F;
        wr(10'h004, mux_m);
        new_obs();
        @(negedge clk);
        check("R5 mixed", 32'(pins), 32'(exp_pins(1'b1, mux_m, gpo_m, obs)));

        // R6 disable gating
        wr(10'h000, 32'h0);
        @(negedge clk);
        check("R6 pins low", 32'(pins), 32'h0);
        wr(10'h014, 32'h40);
        gpo_m = 8'h6E;
        new_obs();
        @(negedge clk);
        check("R6 pins stay low", 32'(pins), 32'h0);
        rd(10'h004, rv); check("R6 mux kept", rv, mux_m);
        rd(10'h01C, rv); check("R6 gpo kept", rv, 32'h6E);
        rd(10'h010, rv); check("R9 value while off", rv, 32'h0);
        wr(10'h000, 32'h1);
        @(negedge clk);
        check("R6 routing restored", 32'(pins), 32'(exp_pins(1'b1, mux_m, gpo_m, obs)));

        // R9 read-only offsets
        wr(10'h010, 32'hFFFF_FFFF);
        wr(10'h01C, 32'h0);
        wr(10'h3F4, 32'h0);
        wr(10'h3F8, 32'h0);
        wr(10'h3FC, 32'h0);
        rd(10'h01C, rv); check("R9 gpo unchanged", rv, 32'h6E);
        rd(10'h004, rv); check("R9 mux unchanged", rv, mux_m);
        rd(10'h010, rv); check("R9 value reads pins", rv, 32'(exp_pins(1'b1, mux_m, gpo_m, obs)));

        // R10 identification
        rd(10'h3F8, rv); check("R10 ident", rv, 32'h4442_4730);
        rd(10'h3FC, rv); check("R10 size", rv, 32'h0000_0008);
        rd(10'h100, rv); check("R10 unmapped", rv, 32'h0);
        rd(10'h3F4, rv); check("R10 version", rv, 32'h21);

        // R11 read data holds across writes
        wr(10'h014, 32'h01);
        wr(10'h004, 32'h0);
        @(negedge clk);
        check("R11 rdata held", rdata, 32'h21);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule